// File: doc/BRIEF.md
# Bank-Switching Address Decoder

This block sits between a CPU with a 10-bit address bus and a 64 KiB physical memory. CPU address bit 9 splits the CPU's view into two 512-byte halves. The lower half shows whichever 512-byte physical bank the bank register names. The upper half always shows the last physical bank. CPU address bit 9 is never passed to memory. It only steers a mux that picks either the bank register or the constant bank number for the upper physical address bits.

The top bit of the selected bank picks the memory device, so the choice between ROM and RAM follows the bank and not the CPU address. The eight highest CPU addresses form an I/O window. Accesses there raise an I/O flag and enable no memory device. One port in the window loads the bank register. Another port returns an 8-bit tick count that advances once every 16 clocks, which is 3.2 µs at 5 MHz.

Top module: `bank_decoder`

## Requirements
- R1: While reset is held, and after it is released, the bank register reads 0, the tick count reads 0, and CPU address 0x000 maps to physical address 0x0000.
- R2: The physical address is `{bank[6:0], cpu_addr[8:0]}`. Physical bit 9 is bank bit 0. CPU address bit 9 never appears at the physical address.
- R3: When CPU address bit 9 is 1, the physical bank is 127 (physical bits 15..9 all ones), whatever the bank register holds.
- R4: A cycle with `cpu_req_i=1`, `cpu_we_i=1` and address 0x3F8 loads `cpu_wdata_i[6:0]` into the bank register at that clock edge. Data bit 7 is ignored.
- R5: When CPU address bit 9 is 0, the physical bank equals the bank register.
- R6: With `cpu_req_i=1` outside the I/O window, `rom_cs_o` is high for banks 0–63 and `ram_cs_o` is high for banks 64–127. Both are low when `cpu_req_i=0`.
- R7: CPU addresses 0x3F8–0x3FF form the I/O window. An access there sets `io_sel_o=1` (only while `cpu_req_i=1`) and holds both chip selects low.
- R8: `io_rdata_o` returns the bank register in bits 6..0 (bit 7 zero) at 0x3F8, the tick count at 0x3F9, and 0 at the other ports.
- R9: The tick count advances by one on every 16th clock edge after reset is released. It wraps from 255 to 0.
- R10: A write to any other I/O port, a write to a memory address, and a write with `cpu_req_i=0` all leave the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access valid this cycle |
| cpu_we_i | input | 1 | Access is a store |
| cpu_addr_i | input | 10 | CPU address |
| cpu_wdata_i | input | 8 | CPU store data |
| phys_addr_o | output | 16 | Physical memory address |
| rom_cs_o | output | 1 | ROM chip select, active high |
| ram_cs_o | output | 1 | RAM chip select, active high |
| io_sel_o | output | 1 | Access falls in the I/O window |
| io_rdata_o | output | 8 | Read data of the addressed I/O port |

## Verification
Two functions can act on the same clock edge: a store to the bank port, and the prescaler rolling the tick count over. The bench keeps its own count of clock edges since reset. It uses that count to place a bank store exactly on a rollover edge. It then reads both ports back and compares them with the value it stored and with the tick value computed from its edge count. Every tick read elsewhere in the run is also checked exactly against that edge count.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int CPU_AW   = 10;
  localparam int BANK_W   = 7;
  localparam int DATA_W   = 8;
  localparam int IO_PORTS = 8;
  localparam int TICK_W   = 8;
  localparam int TICK_DIV = 16;

  // port indices inside the I/O window
  localparam int PORT_BANK = 0;
  localparam int PORT_TICK = 1;
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
  parameter int BANK_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (wr_hit_i) bank_q <= wdata_i[BANK_W-1:0];
  end

  assign bank_o = bank_q;

  a_r4_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> bank_o == $past(wdata_i[BANK_W-1:0]));
  a_r10_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(bank_o));
endmodule

// File: rtl/addr_map.sv
module addr_map #(
  parameter int CPU_AW   = 10,
  parameter int BANK_W   = 7,
  parameter int IO_PORTS = 8,
  localparam int OFS_W   = CPU_AW - 1,
  localparam int PHYS_AW = BANK_W + OFS_W,
  localparam int IO_W    = $clog2(IO_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [CPU_AW-1:0]  addr_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic [PHYS_AW-1:0] phys_o,
  output logic               io_hit_o,
  output logic               rom_cs_o,
  output logic               ram_cs_o,
  output logic               io_sel_o
);
  localparam logic [BANK_W-1:0] FIXED_BANK = '1;

  logic [BANK_W-1:0] sel_bank;
  logic              blk1;

  assign blk1     = addr_i[CPU_AW-1];
  assign sel_bank = blk1 ? FIXED_BANK : bank_i;
  assign phys_o   = {sel_bank, addr_i[OFS_W-1:0]};
  assign io_hit_o = &addr_i[CPU_AW-1:IO_W];

  always_comb begin
    rom_cs_o = 1'b0;
    ram_cs_o = 1'b0;
    if (req_i && !io_hit_o) begin
      // top bank bit splits ROM (low half) from RAM (high half)
      if (sel_bank[BANK_W-1]) ram_cs_o = 1'b1;
      else                    rom_cs_o = 1'b1;
    end
  end
  assign io_sel_o = req_i & io_hit_o;

  a_r3_block1_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[CPU_AW-1] |-> phys_o[PHYS_AW-1:OFS_W] == FIXED_BANK);
  a_r7_io_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_o |-> (!rom_cs_o && !ram_cs_o));
  a_r6_cs_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ram_cs_o, io_sel_o}));
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int TICK_W   = 8,
  parameter int TICK_DIV = 16,
  localparam int PRE_W   = $clog2(TICK_DIV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TICK_W-1:0] tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [TICK_W-1:0] tick_q;
  logic              roll;

  assign roll = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q <= roll ? '0 : pre_q + 1'b1;
      if (roll) tick_q <= tick_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  a_r9_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll |=> tick_o == $past(tick_o) + 1'b1);
  a_r9_tick_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !roll |=> $stable(tick_o));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter int P_CPU_AW   = CPU_AW,
  parameter int P_BANK_W   = BANK_W,
  parameter int P_DATA_W   = DATA_W,
  parameter int P_IO_PORTS = IO_PORTS,
  parameter int P_TICK_W   = TICK_W,
  parameter int P_TICK_DIV = TICK_DIV,
  localparam int PHYS_AW   = P_BANK_W + P_CPU_AW - 1,
  localparam int IO_W      = $clog2(P_IO_PORTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [P_CPU_AW-1:0] cpu_addr_i,
  input  logic [P_DATA_W-1:0] cpu_wdata_i,
  output logic [PHYS_AW-1:0]  phys_addr_o,
  output logic                rom_cs_o,
  output logic                ram_cs_o,
  output logic                io_sel_o,
  output logic [P_DATA_W-1:0] io_rdata_o
);
  logic [P_BANK_W-1:0] bank;
  logic [P_TICK_W-1:0] tick;
  logic                io_hit;
  logic [IO_W-1:0]     port;
  logic                bank_wr;

  assign port    = cpu_addr_i[IO_W-1:0];
  assign bank_wr = cpu_req_i & cpu_we_i & io_hit & (port == IO_W'(PORT_BANK));

  bank_select_reg #(.BANK_W(P_BANK_W), .DATA_W(P_DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hit_i(bank_wr),
    .wdata_i(cpu_wdata_i), .bank_o(bank));

  addr_map #(.CPU_AW(P_CPU_AW), .BANK_W(P_BANK_W), .IO_PORTS(P_IO_PORTS)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(cpu_req_i), .addr_i(cpu_addr_i),
    .bank_i(bank), .phys_o(phys_addr_o), .io_hit_o(io_hit),
    .rom_cs_o(rom_cs_o), .ram_cs_o(ram_cs_o), .io_sel_o(io_sel_o));

  tick_gen #(.TICK_W(P_TICK_W), .TICK_DIV(P_TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  always_comb begin
    io_rdata_o = '0;
    if (io_hit) begin
      if (port == IO_W'(PORT_BANK))      io_rdata_o = P_DATA_W'(bank);
      else if (port == IO_W'(PORT_TICK)) io_rdata_o = P_DATA_W'(tick);
    end
  end

  a_r2_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[P_CPU_AW-2:0] == cpu_addr_i[P_CPU_AW-2:0]);
  a_r5_block0_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_addr_i[P_CPU_AW-1] && io_rdata_o == '0 && $past(bank_wr) == 1'b0
      && $stable(bank)) |-> phys_addr_o[PHYS_AW-1:P_CPU_AW-1] == $past(bank));
endmodule

// File: tb/bank_decoder_bench.sv
module bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] phys;
  logic        rom_cs, ram_cs, io_sel;
  logic [7:0]  rdata;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  bank_decoder u_bank_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .phys_addr_o(phys),
    .rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .io_sel_o(io_sel), .io_rdata_o(rdata));

  typedef struct packed {
    logic [7:0]  wr;
    logic [9:0]  addr;
    logic [15:0] phys;
    logic        rom, ram, io;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 10'h000, 16'h0000, 1'b1, 1'b0, 1'b0},
    '{8'h81, 10'h1FF, 16'h03FF, 1'b1, 1'b0, 1'b0},
    '{8'h3F, 10'h0AA, 16'h7EAA, 1'b1, 1'b0, 1'b0},
    '{8'hC0, 10'h055, 16'h8055, 1'b0, 1'b1, 1'b0},
    '{8'h7F, 10'h100, 16'hFF00, 1'b0, 1'b1, 1'b0},
    '{8'h15, 10'h200, 16'hFE00, 1'b0, 1'b1, 1'b0},
    '{8'h40, 10'h3F7, 16'hFFF7, 1'b0, 1'b1, 1'b0},
    '{8'h00, 10'h3FC, 16'hFFFC, 1'b0, 1'b0, 1'b1},
    '{8'h2A, 10'h3F8, 16'hFFF8, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [9:0] a, logic [7:0] d, logic r);
    @(negedge clk);
    req = r; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [9:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
  endtask

  function automatic logic [7:0] exp_tick();
    return 8'((cyc / 16) % 256);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, checked while held and after release
    #1; req = 1'b1; addr = 10'h3F8; #1;
    check("R1 bank in reset", 16'(rdata), 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(10'h3F9);
    check("R1 tick after reset", 16'(rdata), 16'(exp_tick()));
    bus_read(10'h000);
    check("R1 phys after reset", phys, 16'h0000);

    // table: R2 R3 R5 R6 R7, writes with bit 7 set exercise R4
    for (int i = 0; i < NV; i++) begin
      bus_write(10'h3F8, VECS[i].wr, 1'b1);
      bus_read(VECS[i].addr);
      check("R2/R3/R5 phys", phys, VECS[i].phys);
      check("R6 rom_cs", 16'(rom_cs), 16'(VECS[i].rom));
      check("R6 ram_cs", 16'(ram_cs), 16'(VECS[i].ram));
      check("R7 io_sel", 16'(io_sel), 16'(VECS[i].io));
      bus_read(10'h3F8);
      check("R4 R8 bank readback", 16'(rdata), 16'(VECS[i].wr & 8'h7F));
    end

    // R6: no request, no selects
    @(negedge clk); req = 1'b0; addr = 10'h010; #1;
    check("R6 idle rom", 16'(rom_cs), 16'h0);
    check("R6 idle ram", 16'(ram_cs), 16'h0);
    check("R7 idle io", 16'(io_sel), 16'h0);

    // R4: new bank visible on the very next cycle
    bus_write(10'h3F8, 8'h05, 1'b1);
    bus_read(10'h123);
    check("R4 next cycle", phys, 16'h0B23);

    // R10: stores that must not touch the bank
    bus_write(10'h3FA, 8'h33, 1'b1);
    bus_write(10'h018, 8'h44, 1'b1);
    bus_write(10'h3F8, 8'h55, 1'b0);
    bus_read(10'h3F8);
    check("R10 bank unchanged", 16'(rdata), 16'h0005);
    bus_read(10'h020);
    check("R10 phys unchanged", phys, 16'h0A20);

    // R8: other ports read zero
    bus_read(10'h3FD);
    check("R8 idle port", 16'(rdata), 16'h0000);

    // R9: exact tick against edge count, then one step
    bus_read(10'h3F9);
    check("R9 tick value", 16'(rdata), 16'(exp_tick()));
    while (cyc % 16 != 0) @(negedge clk);
    begin
      logic [7:0] t0;
      t0 = rdata;
      repeat (16) @(negedge clk);
      #1;
      check("R9 tick step", 16'(rdata), 16'(t0 + 8'd1));
    end

    // coincidence: bank store on the tick rollover edge
    @(negedge clk);
    while ((cyc + 1) % 16 != 0) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 10'h3F8; wdata = 8'h6C;
    @(negedge clk);
    we = 1'b0; #1;
    check("R4 store on rollover", 16'(rdata), 16'h006C);
    addr = 10'h3F9; #1;
    check("R9 tick on store edge", 16'(rdata), 16'(exp_tick()));

    // R9: wrap 255 -> 0
    while (exp_tick() != 8'd255) @(negedge clk);
    #1;
    check("R9 tick 255", 16'(rdata), 16'h00FF);
    while (exp_tick() != 8'd0) @(negedge clk);
    #1;
    check("R9 tick wrap", 16'(rdata), 16'h0000);

    req = 1'b0;
    finish_run();
  end
endmodule